// File: doc/BRIEF.md
# Wiper Setting Store and Restore Controller

This block sits between a command decoder and the two wiper-position registers of a dual-channel digital potentiometer. It keeps sixteen 8-bit nonvolatile bytes, modelled as registers. Each command carries a 4-bit operation code, a 4-bit address and a data byte. Addresses 0 and 1 hold the saved settings for wiper 1 and wiper 2. Addresses 2 to 15 are fourteen general-purpose bytes, numbered user 1 to user 14 as the address rises.

When reset is released, the block copies both saved settings into the live wiper registers before it accepts any command. The host can store bytes, fetch bytes, and copy a saved setting back into its wiper. One of the two restore operations puts the block into a higher-power read state. Only an explicit no-operation command takes it out of that state. A store keeps the block busy for a fixed number of cycles, which stands for the programming time of the storage. Each wiper value is also decoded into a one-hot select over 256 taps.

Top module: `nvRestoreCtl`

## Requirements
- R1: While reset is low and in the first cycle after its release, cmdReady is 0 and readModeActive is 0. In the following cycle, wiper1 equals INIT_W1, wiper2 equals INIT_W2 and cmdReady is 1.
- R2: A command with code 3 writes cmdData into the stored byte at cmdAddr, for any address 0 to 15. Address 0 holds the wiper 1 setting, address 1 holds the wiper 2 setting, and addresses 2 to 15 hold user bytes.
- R3: After a code 3 command is accepted, busy is 1 and cmdReady is 0 for exactly WRITE_CYCLES cycles.
- R4: In the cycle after a code 9 command is accepted, rdValid is 1 for one cycle and rdData holds the stored byte at cmdAddr.
- R5: Codes 1 and 8 with address 0 copy stored byte 0 into wiper1 in the next cycle. With address 1, they copy stored byte 1 into wiper2. With any other address, both wipers keep their values. Nothing else changes a wiper after power-on.
- R6: Accepting code 1 sets readModeActive in the next cycle, whatever the address. Accepting code 0 clears it. Codes 3, 8 and 9 leave it unchanged.
- R7: Codes 2, 4 to 7 and 10 to 15 change no wiper, no stored byte, no read output and no readModeActive.
- R8: tapSel1 and tapSel2 each have exactly one bit set, at the index equal to wiper1 and wiper2 respectively, in the same cycle as the wiper value.
- R9: A command presented while cmdReady is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset (power-on) |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 4 | Operation code |
| cmdAddr | input | 4 | Storage or wiper address |
| cmdData | input | 8 | Byte to store |
| cmdReady | output | 1 | Command accepted this cycle if valid |
| busy | output | 1 | Storage programming in progress |
| readModeActive | output | 1 | Higher-power read state |
| rdValid | output | 1 | Fetched byte valid |
| rdData | output | 8 | Fetched byte |
| wiper1 | output | 8 | Live wiper 1 position |
| wiper2 | output | 8 | Live wiper 2 position |
| tapSel1 | output | 256 | One-hot tap select for wiper 1 |
| tapSel2 | output | 256 | One-hot tap select for wiper 2 |

## Verification
Each internal error shows up at the ports within a bounded number of cycles. A stored byte that is corrupted stays hidden until it is fetched, or until a restore copies it into a wiper. In either case it appears on rdData or on a wiper one cycle after that command. A wrong busy count shows up at once as cmdReady rising too early or too late. A read-mode flag that is wrong, or that some code clears when it should not, shows on readModeActive in the cycle after the command. The bench compares all outputs with its own model on every cycle. It also runs a long stretch of random commands, so a hidden error has many chances to be fetched or restored.

// File: rtl/nvRestorePkg.sv
package nvRestorePkg;
  localparam int NV_ADDR_W   = 4;
  localparam int NV_DATA_W   = 8;
  localparam int OP_W        = 4;
  localparam int WIPER_COUNT = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NOP        = 4'd0,
    OP_RESTORE_RM = 4'd1,
    OP_STORE      = 4'd3,
    OP_RESTORE    = 4'd8,
    OP_FETCH      = 4'd9
  } nvOp_e;

  typedef struct packed {
    logic                 bootLoad;
    logic                 restoreEn;
    logic                 nvWrite;
    logic                 nvRead;
    logic [NV_ADDR_W-1:0] addr;
    logic [NV_DATA_W-1:0] data;
  } nvStrobes_t;
endpackage

// File: rtl/tapDecoder.sv
module tapDecoder #(
  parameter int VAL_W = 8,
  localparam int TAPS = 1 << VAL_W
) (
  input  logic [VAL_W-1:0] value,
  output logic [TAPS-1:0]  sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign sel[i] = (value == VAL_W'(i));
  end
endmodule

// File: rtl/nvCtrl.sv
module nvCtrl
  import nvRestorePkg::*;
#(
  parameter int WRITE_CYCLES = 6,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [OP_W-1:0]      cmdOp,
  input  logic [NV_ADDR_W-1:0] cmdAddr,
  input  logic [NV_DATA_W-1:0] cmdData,
  output logic                 cmdReady,
  output logic                 busy,
  output logic                 readModeActive,
  output nvStrobes_t           strobes
);
  logic             bootingQ;
  logic [CNT_W-1:0] busyCnt;
  logic             accept;
  logic             isRestore;
  logic             isKnown;

  always_comb begin
    cmdReady  = !bootingQ && (busyCnt == '0);
    busy      = (busyCnt != '0);
    accept    = cmdValid && cmdReady;
    isRestore = (cmdOp == OP_RESTORE_RM) || (cmdOp == OP_RESTORE);
    isKnown   = isRestore || (cmdOp == OP_NOP) || (cmdOp == OP_STORE) ||
                (cmdOp == OP_FETCH);
    strobes.bootLoad  = bootingQ;
    strobes.restoreEn = accept && isRestore &&
                        (cmdAddr < NV_ADDR_W'(WIPER_COUNT));
    strobes.nvWrite   = accept && (cmdOp == OP_STORE);
    strobes.nvRead    = accept && (cmdOp == OP_FETCH);
    strobes.addr      = cmdAddr;
    strobes.data      = cmdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootingQ       <= 1'b1;
      busyCnt        <= '0;
      readModeActive <= 1'b0;
    end else begin
      bootingQ <= 1'b0;
      if (accept && (cmdOp == OP_STORE))
        busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - CNT_W'(1);
      if (accept && (cmdOp == OP_NOP))
        readModeActive <= 1'b0;
      else if (accept && (cmdOp == OP_RESTORE_RM))
        readModeActive <= 1'b1;
    end
  end

  AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == OP_STORE) |=> (busy && !cmdReady)); // R3
  AST_NOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == OP_NOP) |=> !readModeActive); // R6
  AST_RM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == OP_RESTORE_RM) |=> readModeActive); // R6
  AST_UNKNOWN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !isKnown) |=> $stable(readModeActive)); // R7
  AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !(strobes.nvWrite || strobes.nvRead || strobes.restoreEn)); // R9
endmodule

// File: rtl/nvDatapath.sv
module nvDatapath
  import nvRestorePkg::*;
#(
  parameter logic [NV_DATA_W-1:0] INIT_W1   = 8'h80,
  parameter logic [NV_DATA_W-1:0] INIT_W2   = 8'h20,
  parameter logic [NV_DATA_W-1:0] USER_INIT = 8'h00,
  localparam int NV_DEPTH = 1 << NV_ADDR_W,
  localparam int TAPS     = 1 << NV_DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nvStrobes_t           strobes,
  output logic                 rdValid,
  output logic [NV_DATA_W-1:0] rdData,
  output logic [NV_DATA_W-1:0] wiper1,
  output logic [NV_DATA_W-1:0] wiper2,
  output logic [TAPS-1:0]      tapSel1,
  output logic [TAPS-1:0]      tapSel2
);
  logic [NV_DATA_W-1:0] nvMem [NV_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NV_DEPTH; i++)
        nvMem[i] <= (i == 0) ? INIT_W1 : (i == 1) ? INIT_W2 : USER_INIT;
      wiper1  <= '0;
      wiper2  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.nvRead;
      if (strobes.nvRead) rdData <= nvMem[strobes.addr];
      if (strobes.nvWrite) nvMem[strobes.addr] <= strobes.data;
      if (strobes.bootLoad) begin
        wiper1 <= nvMem[0];
        wiper2 <= nvMem[1];
      end else if (strobes.restoreEn) begin
        if (strobes.addr[0]) wiper2 <= nvMem[1];
        else                 wiper1 <= nvMem[0];
      end
    end
  end

  tapDecoder #(.VAL_W(NV_DATA_W)) i_tap1 (.value(wiper1), .sel(tapSel1));
  tapDecoder #(.VAL_W(NV_DATA_W)) i_tap2 (.value(wiper2), .sel(tapSel2));

  AST_TAP1_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel1) == 1); // R8
  AST_TAP2_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel2) == 1); // R8
  AST_WIPER1_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.bootLoad && !strobes.restoreEn) |=> $stable(wiper1)); // R5
  AST_WIPER2_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.bootLoad && !strobes.restoreEn) |=> $stable(wiper2)); // R5
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nvRead |=> rdValid); // R4
  AST_BOOT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bootLoad |=> (wiper1 == nvMem[0] && wiper2 == nvMem[1])); // R1
endmodule

// File: rtl/nvRestoreCtl.sv
module nvRestoreCtl
  import nvRestorePkg::*;
#(
  parameter int WRITE_CYCLES = 6,
  parameter logic [7:0] INIT_W1   = 8'h80,
  parameter logic [7:0] INIT_W2   = 8'h20,
  parameter logic [7:0] USER_INIT = 8'h00
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [3:0]   cmdOp,
  input  logic [3:0]   cmdAddr,
  input  logic [7:0]   cmdData,
  output logic         cmdReady,
  output logic         busy,
  output logic         readModeActive,
  output logic         rdValid,
  output logic [7:0]   rdData,
  output logic [7:0]   wiper1,
  output logic [7:0]   wiper2,
  output logic [255:0] tapSel1,
  output logic [255:0] tapSel2
);
  nvStrobes_t strobes;

  nvCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) i_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdAddr, .cmdData,
    .cmdReady, .busy, .readModeActive, .strobes
  );

  nvDatapath #(.INIT_W1(INIT_W1), .INIT_W2(INIT_W2), .USER_INIT(USER_INIT)) i_dp (
    .clk, .rstN, .strobes, .rdValid, .rdData, .wiper1, .wiper2, .tapSel1, .tapSel2
  );
endmodule

// File: tb/test_nvRestoreCtl.sv
module test_nvRestoreCtl;
  localparam int WC = 6;
  localparam logic [7:0] IW1 = 8'h80;
  localparam logic [7:0] IW2 = 8'h20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [3:0] cmdOp = '0, cmdAddr = '0;
  logic [7:0] cmdData = '0;
  logic cmdReady, busy, readModeActive, rdValid;
  logic [7:0] rdData, wiper1, wiper2;
  logic [255:0] tapSel1, tapSel2;

  int total = 0, bad = 0;
  bit cmpOn = 0;

  always #2.5 clk = ~clk;

  nvRestoreCtl #(.WRITE_CYCLES(WC), .INIT_W1(IW1), .INIT_W2(IW2), .USER_INIT(8'h00))
    i_nvRestoreCtl (.*);

  // behavioural reference model
  int mNv[16];
  int mW1, mW2, mBusy, mRd;
  bit mBoot, mRm, mRdv;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mNv[i] = (i == 0) ? IW1 : (i == 1) ? IW2 : 0;
      mW1 = 0; mW2 = 0; mBusy = 0; mBoot = 1; mRm = 0; mRdv = 0; mRd = 0;
    end else begin
      bit acc;
      int op, ad;
      acc = cmdValid && !mBoot && (mBusy == 0);
      op = cmdOp; ad = cmdAddr;
      mRdv = acc && op == 9;
      if (mRdv) mRd = mNv[ad];
      if (mBoot) begin mW1 = mNv[0]; mW2 = mNv[1]; mBoot = 0; end
      else if (acc && (op == 1 || op == 8)) begin
        if (ad == 0) mW1 = mNv[0];
        else if (ad == 1) mW2 = mNv[1];
      end
      if (mBusy > 0) mBusy--;
      if (acc && op == 3) begin mNv[ad] = cmdData; mBusy = WC; end
      if (acc && op == 0) mRm = 0;
      if (acc && op == 1) mRm = 1;
    end
  end

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [255:0] one;
      one = 256'd1;
      check("R1/R9 cmdReady", 256'(cmdReady), 256'(!mBoot && mBusy == 0));
      check("R3 busy", 256'(busy), 256'(mBusy != 0));
      check("R6 readModeActive", 256'(readModeActive), 256'(mRm));
      check("R4 rdValid", 256'(rdValid), 256'(mRdv));
      if (mRdv) check("R4 rdData", 256'(rdData), 256'(mRd));
      check("R5 wiper1", 256'(wiper1), 256'(mW1));
      check("R5 wiper2", 256'(wiper2), 256'(mW2));
      check("R8 tapSel1", tapSel1, one << mW1);
      check("R8 tapSel2", tapSel2, one << mW2);
    end
  end

  task automatic sendCmd(int op, int ad, int dat);
    do @(negedge clk); while (!cmdReady);
    cmdValid = 1'b1; cmdOp = 4'(op); cmdAddr = 4'(ad); cmdData = 8'(dat);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pokeCmd(int op, int ad, int dat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 4'(op); cmdAddr = 4'(ad); cmdData = 8'(dat);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ops[8] = '{0, 1, 3, 8, 9, 2, 5, 12};
    repeat (3) @(negedge clk);
    check("R1 reset ready", 256'(cmdReady), 256'(0));
    check("R1 reset readMode", 256'(readModeActive), 256'(0));
    cmpOn = 1;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 boot wiper1", 256'(wiper1), 256'(IW1));
    check("R1 boot wiper2", 256'(wiper2), 256'(IW2));
    sendCmd(3, 0, 'h11);
    check("R3 busy after store", 256'(busy), 256'(1));
    sendCmd(3, 1, 'h22);
    sendCmd(3, 7, 'hA5);
    sendCmd(9, 7, 0);
    check("R2 stored user byte", 256'(rdData), 256'('hA5));
    sendCmd(1, 0, 0);
    check("R5 restore wiper1", 256'(wiper1), 256'('h11));
    check("R6 read mode set", 256'(readModeActive), 256'(1));
    sendCmd(8, 1, 0);
    check("R5 restore wiper2", 256'(wiper2), 256'('h22));
    sendCmd(1, 6, 0);
    check("R5 bad address wiper1", 256'(wiper1), 256'('h11));
    sendCmd(5, 0, 0);
    check("R7 unknown keeps read mode", 256'(readModeActive), 256'(1));
    sendCmd(0, 0, 0);
    check("R6 nop clears", 256'(readModeActive), 256'(0));
    sendCmd(3, 0, 'h33);
    pokeCmd(8, 0, 0);
    check("R9 held-off restore", 256'(wiper1), 256'('h11));
    sendCmd(9, 0, 0);
    check("R2 wiper slot stored", 256'(rdData), 256'('h33));
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cmdValid = 1'($urandom);
      cmdOp = 4'(ops[$urandom % 8]);
      cmdAddr = 4'($urandom);
      cmdData = 8'($urandom);
    end
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule